// File: doc/BRIEF.md
# Sliding-Window Maximum Tracker

The tracker accepts a stream of signed samples over a valid/ready handshake. After each accepted sample it reports the largest value among the most recent `WIN` accepted samples, which is 512 by default. This is an exact windowed maximum. A large value stops counting once `WIN` newer samples have arrived, unlike a running maximum that holds the largest value since reset.

Instead of a comparator tree over a register file, the block keeps a monotonic double-ended queue in an inferable block RAM. Each entry holds a sample value and a wrapping sample sequence number.

- Every entry that the new sample equals or exceeds is removed from the back of the queue, one entry per clock.
- The new sample is then written at the back.
- The front entry leaves the queue when its sequence number shows it has fallen out of the window.
- The front of the queue is always the window maximum. It is registered onto the output together with a one-cycle strobe.

After reset the history behaves as if it held `WIN` zero samples. While the queue is being updated the input is held off, which bounds the back-pressure to a little more than `WIN` cycles per sample.

Top module: `window_max_tracker`

## Requirements
- R1: `in_data` is a two's-complement signed value of `DW` bits (16 by default), and all ordering between samples is signed, so a negative sample never outranks zero or a positive sample.
- R2: Each result on `max_value` equals the largest of the last `WIN` accepted samples (512 by default), counting the sample just accepted.
- R3: A sample stops influencing the result once `WIN` further samples have been accepted after it, even when it is larger than everything that follows.
- R4: While `rst` is high and in the cycle after it falls, `max_value` is 0 and `max_valid` is 0. After reset the history counts as `WIN` zero samples, so a run of negative samples reports 0 until `WIN` of them have been accepted.
- R5: A sample is taken on a clock edge where both `in_valid` and `in_ready` are 1. `in_ready` is 0 during reset, 0 in the cycle after each acceptance, and 1 again by the cycle in which `max_valid` pulses.
- R6: Each accepted sample yields exactly one `max_valid` pulse, lasting one cycle. `max_value` changes only together with such a pulse.
- R7: Repeated equal samples are handled correctly: ties never lose the maximum, and they never let a stale copy outlive the window.
- R8: `max_valid` pulses no more than `WIN+4` clock edges after the edge that accepted the sample.
- R9: A strictly decreasing run longer than `WIN` fills the queue to its capacity without loss, and the queue never holds more than `WIN` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | DW | Signed sample value |
| in_ready | output | 1 | Block can take a sample this cycle |
| max_value | output | DW | Registered window maximum |
| max_valid | output | 1 | One-cycle strobe: a new `max_value` is available |

## Verification
The assertions assume the sender follows the valid/ready rule. They also assume `WIN` is a power of two, so that the wrapping sequence number repeats exactly every window. The stimulus offers a new sample only after the result for the previous one has appeared and never changes data while it waits for `in_ready`. Under those conditions the queue occupancy, pulse shape and ready timing properties must hold. The sample sequences aim at the queue's edge states: full occupancy from decreasing runs, a full flush from a new maximum, long runs of equal values, negative-only streams against the zero history, and a reset in the middle of a stream.

// File: rtl/wmax_pkg.sv
package wmax_pkg;

  // Control states of the queue engine.
  typedef enum logic [2:0] {
    ST_INIT,  // seed the queue with the zero history entry
    ST_IDLE,  // waiting for a sample, front expiry decided here
    ST_EXP,   // reload the cached front entry after an expiry
    ST_RD,    // issue the first read of the back entry
    ST_CMP,   // compare back entry, remove one per cycle
    ST_APP    // append new sample, publish result
  } wmax_state_e;

endpackage

// File: rtl/wmax_dpram.sv
// One write port, one synchronous read port; no reset on the array so
// that it maps onto block RAM.
module wmax_dpram #(
  parameter int EW    = 25,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_data
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/wmax_ctrl.sv
// Monotonic queue control: pointers, occupancy, sequence numbers and
// the registered result.
module wmax_ctrl
  import wmax_pkg::*;
#(
  parameter int DW  = 16,
  parameter int WIN = 512,
  localparam int AW = $clog2(WIN),
  localparam int CW = AW + 1,
  localparam int EW = DW + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [EW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [EW-1:0] wr_data,
  output logic          res_valid,
  output logic [DW-1:0] res_value
);

  localparam logic [AW-1:0] PONE = AW'(1);
  localparam logic [AW-1:0] PTWO = AW'(2);
  localparam logic [CW-1:0] CONE = CW'(1);

  wmax_state_e   state;
  logic [AW-1:0] head_ptr, tail_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] seq;
  logic [DW-1:0] samp;
  logic [AW-1:0] sidx;
  logic [DW-1:0] head_val;
  logic [AW-1:0] head_idx;

  logic [DW-1:0] rd_val;
  logic [AW-1:0] rd_idx;
  logic          expire;
  logic          pop;

  assign rd_val   = rd_data[EW-1:AW];
  assign rd_idx   = rd_data[AW-1:0];
  assign in_ready = (state == ST_IDLE);

  // With WIN a power of two, "index equals new index minus WIN" reduces
  // to equality of the wrapped sequence numbers.
  assign expire = (count != '0) && (head_idx == seq);
  assign pop    = (state == ST_CMP) && ($signed(rd_val) <= $signed(samp));

  // Read address: data returns one cycle later.
  always_comb begin
    case (state)
      ST_IDLE: rd_addr = head_ptr + PONE;
      ST_RD:   rd_addr = tail_ptr - PONE;
      ST_CMP:  rd_addr = tail_ptr - PTWO;
      default: rd_addr = head_ptr;
    endcase
  end

  always_comb begin
    wr_en   = (state == ST_INIT) || (state == ST_APP);
    wr_addr = (state == ST_INIT) ? '0 : tail_ptr;
    wr_data = (state == ST_INIT) ? {{DW{1'b0}}, {AW{1'b1}}} : {samp, sidx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      head_ptr  <= '0;
      tail_ptr  <= '0;
      count     <= '0;
      seq       <= '0;
      samp      <= '0;
      sidx      <= '0;
      head_val  <= '0;
      head_idx  <= '1;
      res_valid <= 1'b0;
      res_value <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_INIT: begin
          // zero history: one entry, value 0, index one before the first sample
          tail_ptr <= PONE;
          count    <= CONE;
          state    <= ST_IDLE;
        end
        ST_IDLE: begin
          if (in_valid) begin
            samp <= in_data;
            sidx <= seq;
            seq  <= seq + PONE;
            if (expire) begin
              head_ptr <= head_ptr + PONE;
              count    <= count - CONE;
              state    <= ST_EXP;
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_EXP: begin
          head_val <= rd_val;
          head_idx <= rd_idx;
          state    <= ST_RD;
        end
        ST_RD: begin
          state <= (count == '0) ? ST_APP : ST_CMP;
        end
        ST_CMP: begin
          if (pop) begin
            tail_ptr <= tail_ptr - PONE;
            count    <= count - CONE;
            if (count == CONE) state <= ST_APP;
          end else begin
            state <= ST_APP;
          end
        end
        ST_APP: begin
          tail_ptr  <= tail_ptr + PONE;
          count     <= count + CONE;
          if (count == '0) begin
            head_val <= samp;
            head_idx <= sidx;
          end
          res_value <= (count == '0) ? samp : head_val;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  // R9: occupancy never exceeds the window
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(WIN));

  // R6: result strobe lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R6: result only moves with a strobe
  p_value_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_value));

  // R5: busy right after an acceptance
  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R5: ready again when the result appears
  p_ready_on_result_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> in_ready);

  // R4: result cleared by reset
  p_reset_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_value == '0 && !res_valid));

  // R3: an appended entry never carries an expired index as the front
  p_front_live_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && count != '0) |-> (head_idx != sidx));

endmodule

// File: rtl/window_max_tracker.sv
module window_max_tracker #(
  parameter int DW  = 16,
  parameter int WIN = 512,
  localparam int AW = $clog2(WIN),
  localparam int EW = DW + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [DW-1:0] max_value,
  output logic          max_valid
);

  logic [AW-1:0] rd_addr, wr_addr;
  logic [EW-1:0] rd_data, wr_data;
  logic          wr_en;

  wmax_ctrl #(.DW(DW), .WIN(WIN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .res_valid(max_valid),
    .res_value(max_value)
  );

  wmax_dpram #(.EW(EW), .DEPTH(WIN)) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

endmodule

// File: tb/window_max_tracker_test.sv
module window_max_tracker_test;

  localparam int DW  = 16;
  localparam int WIN = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [DW-1:0] max_value;
  logic          max_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int accepted = 0;
  int results  = 0;

  logic signed [DW-1:0] hist [WIN];
  int                   wp;
  logic signed [DW-1:0] expq [$];

  always #2.5 clk = ~clk;  // 200 MHz

  window_max_tracker #(.DW(DW), .WIN(WIN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .max_value(max_value), .max_valid(max_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  // monitor: pops the scoreboard on each result strobe (R2, R6)
  always @(negedge clk) begin
    if (!rst && max_valid) begin
      results++;
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected result", int'($signed(max_value)), 0);
      end else begin
        logic signed [DW-1:0] e;
        e = expq.pop_front();
        check($signed(max_value) == e, "R2 window maximum",
              int'($signed(max_value)), int'(e));
      end
      check(in_ready == 1'b1, "R5 ready with result", int'(in_ready), 1);
    end
  end

  task automatic model_reset();
    for (int i = 0; i < WIN; i++) hist[i] = '0;
    wp = 0;
    expq.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R5 not ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(max_value == '0, "R4 max after reset", int'($signed(max_value)), 0);
    check(max_valid == 1'b0, "R4 valid after reset", int'(max_valid), 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R5 ready after init", int'(in_ready), 1);
  endtask

  task automatic send(input logic signed [DW-1:0] v);
    logic signed [DW-1:0] m;
    int lat;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    accepted++;
    hist[wp] = v;
    wp = (wp + 1) % WIN;
    m = hist[0];
    for (int i = 1; i < WIN; i++) if (hist[i] > m) m = hist[i];
    expq.push_back(m);
    lat = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
    end while (!max_valid && lat < WIN + 20);
    check(lat <= WIN + 4, "R8 result latency", lat, WIN + 4);
  endtask

  initial begin
    model_reset();
    do_reset();

    // R1 R4: negatives against the zero history
    for (int i = 0; i < 20; i++) send(DW'(-100 - i));
    check(int'($signed(max_value)) == 0, "R1 R4 negatives under zero history",
          int'($signed(max_value)), 0);

    // R2 R3: random mixed values
    for (int i = 0; i < 1200; i++) send(DW'($urandom));

    // R3: a spike must age out after exactly WIN more samples
    send(DW'(32767));
    for (int i = 0; i < WIN - 1; i++) send(DW'(i % 50));
    check(int'($signed(max_value)) == 32767, "R3 spike still in window",
          int'($signed(max_value)), 32767);
    send(DW'(7));
    check(int'($signed(max_value)) == 49, "R3 spike aged out",
          int'($signed(max_value)), 49);

    // R9: strictly decreasing run longer than the window, then a flush
    for (int i = 0; i < 700; i++) send(DW'(30000 - 40 * i));
    send(DW'(32000));
    check(int'($signed(max_value)) == 32000, "R9 R8 full flush",
          int'($signed(max_value)), 32000);

    // R7: repeated equal values and alternating ties
    for (int i = 0; i < 600; i++) send(DW'(-5));
    check(int'($signed(max_value)) == -5, "R7 equal run",
          int'($signed(max_value)), -5);
    for (int i = 0; i < 300; i++) send((i % 2) ? DW'(123) : DW'(-123));
    for (int i = 0; i < 100; i++) send(DW'(123));

    // R4: reset mid-stream restores the zero history
    do_reset();
    for (int i = 0; i < WIN - 1; i++) send(DW'(-32768 + i));
    check(int'($signed(max_value)) == 0, "R4 zero history kept",
          int'($signed(max_value)), 0);
    send(DW'(-30000));
    check(int'($signed(max_value)) == -30000, "R4 R1 zero history expired",
          int'($signed(max_value)), -30000);

    repeat (5) @(negedge clk);
    // R6: exactly one result per accepted sample
    check(expq.size() == 0, "R6 scoreboard drained", expq.size(), 0);
    check(results == accepted, "R6 one result per sample", results, accepted);
    finish_run();
  end

endmodule